// File: doc/BRIEF.md
# Alarm and Square-Wave Output Pin Selector

This block decides what a single shared output pin carries: a fixed 512 Hz calibration tone, one of four square waves chosen by software, or the alarm event. It works from a 32768 Hz clock and produces two signals for the pad: a data value and an output enable. A low enable means the pin floats (high impedance). In alarm mode the pin behaves like an open-drain line: it pulls low while the alarm flag is set and releases when the flag is cleared.

All square waves come from one free-running 15-bit divider that is cleared only by reset. Each divided output therefore has a 50% duty cycle. The 32768 Hz choice is the input clock passed straight through. The control inputs (calibrate, alarm enable, alarm routing, frequency select) and the alarm flag are registered once on the clock. A change on any of them reaches the pin one clock edge later. Changing the frequency select never restarts the divider, so the newly chosen wave keeps the phase of the free-running count.

Top module: `alarm_wave_pin`

## Requirements
- R1: When `cal_en` is 1, `pin_oe` is 1 and `pin_data` is the 512 Hz wave (divider bit 5, toggling every 32 clocks). `alarm_en`, `alarm_route` and `alarm_flag` have no effect.
- R2: When `cal_en` is 0 and `alarm_route` is 0, `pin_oe` is 1 and `pin_data` is the wave chosen by `freq_sel`, whatever the value of `alarm_en`.
- R3: `freq_sel` encodes the wave as follows. 00 gives 1 Hz (divider bit 14, toggling every 16384 clocks). 01 gives 512 Hz (bit 5). 10 gives 4096 Hz (bit 2, toggling every 4 clocks). 11 gives 32768 Hz, where `pin_data` equals `clk`. Each divided wave is low for the first half of its period, counted from the count after reset.
- R4: When `cal_en` is 0, `alarm_route` is 1 and `alarm_en` is 1, `pin_data` is 0 and `pin_oe` equals the registered `alarm_flag`. The pin is driven low while the flag is set and released when it is clear.
- R5: When `cal_en` is 0, `alarm_route` is 1 and `alarm_en` is 0, `pin_oe` is 0 whatever the values of `alarm_flag` and `freq_sel`.
- R6: While `rst` is high, `pin_oe` is 0 and the divider holds 0. After the first clock edge with `rst` low, the divider counts up by one on every edge.
- R7: A change on any control input or on `alarm_flag` shows at the pins after the next rising clock edge. A change of `freq_sel` does not reset the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz clock, also the 32768 Hz wave source |
| rst | input | 1 | Synchronous active-high reset |
| cal_en | input | 1 | Calibration mode: force 512 Hz on the pin |
| alarm_en | input | 1 | Alarm enable |
| alarm_route | input | 1 | 1 routes the alarm to the pin, 0 routes the square wave |
| freq_sel | input | 2 | Square-wave frequency select |
| alarm_flag | input | 1 | Alarm event flag |
| pin_data | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable; 0 means high impedance |

## Verification
The controls and the flag pass through one register, so any stimulus applied between two edges is due at the pins from the next rising edge onward. The bench drives inputs three quarters of the way through a period. It checks each cycle twice: a quarter period after the rising edge, while the clock is high, and again while it is low, so that the 32768 Hz pass-through is seen in both states. The expected divided waves come from the number of edges the bench counts since reset. This also confirms that switching `freq_sel` keeps the divider phase.

// File: rtl/awp_pkg.sv
package awp_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ   = 2'd0,
    MODE_CAL   = 2'd1,
    MODE_WAVE  = 2'd2,
    MODE_ALARM = 2'd3
  } pin_mode_t;

  localparam logic [1:0] SEL_1HZ   = 2'b00;
  localparam logic [1:0] SEL_512HZ = 2'b01;
  localparam logic [1:0] SEL_4KHZ  = 2'b10;
  localparam logic [1:0] SEL_CLK   = 2'b11;
endpackage

// File: rtl/awp_divider.sv
module awp_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] count
);
  localparam int TOP = DIV_W - 1;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end

  // the top tap rises only when all lower bits wrap to zero (50% duty)
  assert_top_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(count[TOP]) |-> (count[TOP-1:0] == '0));
endmodule

// File: rtl/awp_mode_reg.sv
module awp_mode_reg
  import awp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cal_en,
  input  logic        alarm_en,
  input  logic        alarm_route,
  input  logic [1:0]  freq_sel,
  input  logic        alarm_flag,
  output pin_mode_t   mode_q,
  output logic [1:0]  sel_q,
  output logic        flag_q
);
  pin_mode_t mode_d;

  always_comb begin
    if (cal_en)            mode_d = MODE_CAL;
    else if (!alarm_route) mode_d = MODE_WAVE;
    else if (alarm_en)     mode_d = MODE_ALARM;
    else                   mode_d = MODE_HIZ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_HIZ;
      sel_q  <= SEL_1HZ;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= freq_sel;
      flag_q <= alarm_flag;
    end
  end

  assert_cal_wins_R1: assert property (@(posedge clk) disable iff (rst)
    cal_en |=> (mode_q == MODE_CAL));
  assert_wave_any_en_R2: assert property (@(posedge clk) disable iff (rst)
    (!cal_en && !alarm_route) |=> (mode_q == MODE_WAVE));
  assert_sel_latency_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sel_q == $past(freq_sel)));
endmodule

// File: rtl/awp_pin_drive.sv
module awp_pin_drive
  import awp_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int CAL_TAP = 5,
  parameter int MID_TAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  pin_mode_t        mode_q,
  input  logic [1:0]       sel_q,
  input  logic             flag_q,
  input  logic [DIV_W-1:0] count,
  output logic             pin_data,
  output logic             pin_oe
);
  localparam int SLOW_TAP = DIV_W - 1;

  logic wave;

  always_comb begin
    unique case (sel_q)
      SEL_1HZ:   wave = count[SLOW_TAP];
      SEL_512HZ: wave = count[CAL_TAP];
      SEL_4KHZ:  wave = count[MID_TAP];
      default:   wave = clk;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      MODE_CAL:   begin pin_oe = 1'b1;   pin_data = count[CAL_TAP]; end
      MODE_WAVE:  begin pin_oe = 1'b1;   pin_data = wave;           end
      MODE_ALARM: begin pin_oe = flag_q; pin_data = 1'b0;           end
      default:    begin pin_oe = 1'b0;   pin_data = 1'b0;           end
    endcase
  end

  assert_alarm_open_drain_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ALARM) |-> (!pin_data && (pin_oe == flag_q)));
  assert_hiz_released_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_HIZ) |-> !pin_oe);
endmodule

// File: rtl/alarm_wave_pin.sv
module alarm_wave_pin
  import awp_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int CAL_TAP = 5,
  parameter int MID_TAP = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cal_en,
  input  logic       alarm_en,
  input  logic       alarm_route,
  input  logic [1:0] freq_sel,
  input  logic       alarm_flag,
  output logic       pin_data,
  output logic       pin_oe
);
  logic [DIV_W-1:0] count;
  pin_mode_t        mode_q;
  logic [1:0]       sel_q;
  logic             flag_q;

  awp_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .count(count)
  );

  awp_mode_reg u_mode (
    .clk(clk), .rst(rst), .cal_en(cal_en), .alarm_en(alarm_en),
    .alarm_route(alarm_route), .freq_sel(freq_sel), .alarm_flag(alarm_flag),
    .mode_q(mode_q), .sel_q(sel_q), .flag_q(flag_q)
  );

  awp_pin_drive #(.DIV_W(DIV_W), .CAL_TAP(CAL_TAP), .MID_TAP(MID_TAP)) u_drive (
    .clk(clk), .rst(rst), .mode_q(mode_q), .sel_q(sel_q), .flag_q(flag_q),
    .count(count), .pin_data(pin_data), .pin_oe(pin_oe)
  );
endmodule

// File: tb/alarm_wave_pin_test.sv
module alarm_wave_pin_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_en = 1'b0, alarm_en = 1'b0, alarm_route = 1'b1;
  logic [1:0] freq_sel = 2'b00;
  logic       alarm_flag = 1'b0;
  logic       pin_data, pin_oe;

  int checks = 0;
  int errors = 0;

  alarm_wave_pin uut (
    .clk(clk), .rst(rst), .cal_en(cal_en), .alarm_en(alarm_en),
    .alarm_route(alarm_route), .freq_sel(freq_sel), .alarm_flag(alarm_flag),
    .pin_data(pin_data), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench view of the inputs as seen after each edge, plus edge count
  logic        c_q, e_q, r_q, f_q;
  logic [1:0]  s_q;
  logic [14:0] n_q;
  always @(posedge clk) begin
    if (rst) begin
      c_q <= 0; e_q <= 0; r_q <= 1; f_q <= 0; s_q <= 0; n_q <= 0;
    end else begin
      c_q <= cal_en; e_q <= alarm_en; r_q <= alarm_route;
      f_q <= alarm_flag; s_q <= freq_sel; n_q <= n_q + 15'd1;
    end
  end

  // returns {oe, data}
  function automatic logic [1:0] expect_pin(logic c, logic e, logic r, logic [1:0] s,
                                            logic f, logic [14:0] n, logic k);
    logic w;
    case (s)
      2'b00:   w = n[14];
      2'b01:   w = n[5];
      2'b10:   w = n[2];
      default: w = k;
    endcase
    if (c)       return {1'b1, n[5]};
    else if (!r) return {1'b1, w};
    else if (e)  return {f, 1'b0};
    else         return 2'b00;
  endfunction

  function automatic string tag_of(logic c, logic e, logic r);
    if (c)       return "R1";
    else if (!r) return "R2/R3";
    else if (e)  return "R4";
    else         return "R5";
  endfunction

  task automatic check_pin(string tag);
    logic [1:0] exp;
    string t;
    exp = expect_pin(c_q, e_q, r_q, s_q, f_q, n_q, clk);
    t = (tag == "") ? tag_of(c_q, e_q, r_q) : tag;
    checks++;
    if ({pin_oe, pin_data} !== exp) begin
      errors++;
      $display("FAIL %s t=%0t oe/data actual=%b%b expected=%b%b", t, $time,
               pin_oe, pin_data, exp[1], exp[0]);
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_pin(tag);
    #(CLK_PERIOD/2);
    check_pin(tag);
  endtask

  task automatic set_ctl(logic c, logic e, logic r, logic [1:0] s, logic f);
    cal_en = c; alarm_en = e; alarm_route = r; freq_sel = s; alarm_flag = f;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD*3/4);
    // R6: reset state with pin pushed every way
    set_ctl(1, 1, 0, 2'b11, 1);
    for (int i = 0; i < 4; i++) cycle("R6");
    rst = 1'b0;
    set_ctl(0, 0, 0, 2'b01, 0);
    // R6/R3: 512 Hz phase counted from reset release
    for (int i = 0; i < 80; i++) cycle("R6");
    // R3: 1 Hz needs a full slow period, alarm_en toggled (R2)
    set_ctl(0, 1, 0, 2'b00, 1);
    for (int i = 0; i < 33000; i++) cycle("R3");
    // R7: switch select mid-stream, divider keeps running
    set_ctl(0, 0, 0, 2'b10, 0);
    for (int i = 0; i < 13; i++) cycle("R7");
    set_ctl(0, 0, 0, 2'b11, 0);
    for (int i = 0; i < 5; i++) cycle("R7");
    set_ctl(0, 0, 0, 2'b01, 1);
    for (int i = 0; i < 70; i++) cycle("R7");
    // R4: alarm set then cleared
    set_ctl(0, 1, 1, 2'b10, 1);
    for (int i = 0; i < 6; i++) cycle("R4");
    alarm_flag = 1'b0;
    for (int i = 0; i < 6; i++) cycle("R4");
    // R5: routed but disabled, flag flipping
    set_ctl(0, 0, 1, 2'b11, 1);
    for (int i = 0; i < 6; i++) cycle("R5");
    alarm_flag = 1'b0;
    for (int i = 0; i < 3; i++) cycle("R5");
    // R1: calibration overrides alarm settings
    set_ctl(1, 1, 1, 2'b00, 1);
    for (int i = 0; i < 70; i++) cycle("R1");
    // constrained random: hold settings for random spans
    for (int blk = 0; blk < 300; blk++) begin
      set_ctl($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
              $urandom_range(0, 1) == 1);
      for (int i = 0; i < int'($urandom_range(1, 60)); i++) begin
        cycle("");
        if ($urandom_range(0, 15) == 0) alarm_flag = ~alarm_flag;
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule